// File: doc/BRIEF.md
# Effective Address Generator

This block forms the 16-bit effective address for an 8-bit processor whose memory, peripherals and I/O share one flat 64 KB map. For each instruction the decoder presents the addressing mode, the one or two bytes that follow the opcode, both index registers, the address of the first byte after the opcode and the branch outcome. One clock later the block returns the effective address, a flag that says whether the mode has an address at all, the opcode page in force and the total instruction length in bytes.

Opcode space is split into four pages. A page-select byte in front of the opcode moves decoding from the default page to one of three others. The block watches the byte stream for these selector bytes and holds the selected page until the next instruction issues. The page then goes back to the default. The length it reports counts the selector byte, the opcode and the operand bytes. Opcode meaning and memory access belong to other blocks.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it, `out_valid`, `ea_valid`, `ea`, `ins_len` and `page` are all zero.
- R2: Mode code 2 (zero-page) gives `ea` = {0x00, `opnd_b1`}.
- R3: Mode code 3 (absolute) gives `ea` = {`opnd_b1`, `opnd_b2`}: the first byte after the opcode is the high byte.
- R4: Mode codes 4 and 5 (indexed on `ix` and on `iy`) give `ea` = index + zero-extended `opnd_b1`, modulo 2^16.
- R5: Mode code 6 (branch) gives `ea` = `opnd_pc` + 1 + sign-extended `opnd_b1` when `taken` is 1. When `taken` is 0 it gives `opnd_pc` + 1. Both sums are modulo 2^16.
- R6: Mode code 1 (immediate) gives `ea` = `opnd_pc`.
- R7: Mode code 0 (no operand) and the spare code 7 give `ea_valid` = 0 and `ea` = 0. Every other mode gives `ea_valid` = 1.
- R8: A `pre_we` byte of 0x18, 0x1A or 0xCD selects page 1, 2 or 3. Any other byte leaves the held page unchanged. The held page is reported on `page` with the next instruction and then returns to 0. A selector byte that arrives in the same cycle as `ins_valid` applies to the following instruction. The later of two selector bytes wins.
- R9: `ins_len` = (1 if the page is nonzero, else 0) + 1 + operand bytes. The operand byte counts are:
  - modes 0 and 7: 0
  - mode 1: 2 when `wide` is 1, else 1
  - modes 2, 4, 5 and 6: 1
  - mode 3: 2
- R10: The outputs register the instruction presented with `ins_valid` at that clock edge. `out_valid` is high for exactly that following cycle. Without `ins_valid`, `ea`, `ea_valid`, `ins_len` and `page` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pre_we | input | 1 | A candidate page-select byte is present |
| pre_byte | input | 8 | Candidate page-select byte |
| ins_valid | input | 1 | An instruction is presented this cycle |
| mode | input | 3 | Addressing mode code (0..7, see R2-R7) |
| wide | input | 1 | Immediate operand is 16 bits |
| opnd_b1 | input | 8 | First byte after the opcode |
| opnd_b2 | input | 8 | Second byte after the opcode |
| ix | input | 16 | First index register |
| iy | input | 16 | Second index register |
| opnd_pc | input | 16 | Address of the first byte after the opcode |
| taken | input | 1 | Branch condition is true |
| ea | output | 16 | Effective address |
| ea_valid | output | 1 | Mode produces an effective address |
| ins_len | output | 3 | Instruction length in bytes |
| page | output | 2 | Opcode page used by the instruction |
| out_valid | output | 1 | Outputs describe a newly issued instruction |

## Verification
The hardest case to reach from the ports is the interaction between selector bytes and instruction issue. This covers a selector that arrives in the same cycle as an instruction, a second selector that overrides a first, and a non-selector byte that falls between a selector and its instruction. Random stimulus draws selector codes, random bytes and "none" before each instruction, with varying gaps. Directed sequences then force each of those orderings. Wrap-around of indexed and backward or forward branch sums is forced with index and PC values near both ends of the map.

// File: rtl/ea_gen_pkg.sv
// Package: shared mode encoding and helper functions for the address generator.
// Assumes an 8-bit byte and a 16-bit address bus (two bytes per address).
package ea_gen_pkg;

    typedef enum logic [2:0] {
        AM_NONE = 3'd0,
        AM_IMM  = 3'd1,
        AM_ZPG  = 3'd2,
        AM_ABS  = 3'd3,
        AM_IDXA = 3'd4,
        AM_IDXB = 3'd5,
        AM_BRA  = 3'd6,
        AM_SPARE = 3'd7
    } amode_e;

    // Number of operand bytes that follow the opcode for a given mode.
    function automatic logic [1:0] operand_bytes(input amode_e m, input logic wide16);
        case (m)
            AM_IMM:                        operand_bytes = wide16 ? 2'd2 : 2'd1;
            AM_ZPG, AM_IDXA, AM_IDXB, AM_BRA: operand_bytes = 2'd1;
            AM_ABS:                        operand_bytes = 2'd2;
            default:                       operand_bytes = 2'd0;
        endcase
    endfunction

    // True when a mode produces an effective address.
    function automatic logic mode_has_ea(input amode_e m);
        mode_has_ea = !(m == AM_NONE || m == AM_SPARE);
    endfunction

endpackage

// File: rtl/ea_gen_page.sv
// Page tracker: watches candidate selector bytes and holds the chosen opcode
// page until an instruction issues, then returns to the default page.
// Assumes the selector codes are distinct; code k of SEL_CODES picks page k+1.
module ea_gen_page #(
    parameter int BYTE_W = 8,
    parameter int PAGE_W = 2,
    parameter int NSEL   = 3,
    parameter logic [NSEL*BYTE_W-1:0] SEL_CODES = {8'hCD, 8'h1A, 8'h18}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_we,
    input  logic [BYTE_W-1:0] pre_byte,
    input  logic              ins_valid,
    output logic [PAGE_W-1:0] page_o,
    output logic              sel_cnt_o
);
    logic [NSEL-1:0]   hit;
    logic [PAGE_W-1:0] hit_page;
    logic              any_hit;
    logic [PAGE_W-1:0] page_q;

    // One comparator per extra page.
    for (genvar k = 0; k < NSEL; k++) begin : g_cmp
        assign hit[k] = pre_we && (pre_byte == SEL_CODES[k*BYTE_W +: BYTE_W]);
    end

    // Encode the comparator that matched into a page number.
    always_comb begin
        hit_page = '0;
        for (int k = 0; k < NSEL; k++) begin
            if (hit[k]) hit_page = PAGE_W'(k + 1);
        end
    end

    assign any_hit = |hit;

    // Hold the selected page; issue consumes it, a same-cycle selector re-arms it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (ins_valid) begin
            page_q <= any_hit ? hit_page : '0;
        end else if (any_hit) begin
            page_q <= hit_page;
        end
    end

    assign page_o    = page_q;
    assign sel_cnt_o = (page_q != '0);

    a_r8_page_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !pre_we) |=> (page_o == '0));

    a_r8_other_byte_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_we && !any_hit && !ins_valid) |=> $stable(page_o));

endmodule

// File: rtl/ea_gen_calc.sv
// Address calculator: combinational effective address for one instruction.
// Assumes the address is exactly two bytes wide; all sums wrap modulo 2^ADDR_W.
module ea_gen_calc
    import ea_gen_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16
) (
    input  amode_e            mode,
    input  logic [BYTE_W-1:0] b1,
    input  logic [BYTE_W-1:0] b2,
    input  logic [ADDR_W-1:0] ix,
    input  logic [ADDR_W-1:0] iy,
    input  logic [ADDR_W-1:0] opnd_pc,
    input  logic              taken,
    output logic [ADDR_W-1:0] ea,
    output logic              ea_valid
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] off_zx;
    logic [ADDR_W-1:0] off_sx;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] idx_base;

    // Offset extensions and the sequential address after a one-byte operand.
    always_comb begin
        off_zx   = {{HI_W{1'b0}}, b1};
        off_sx   = {{HI_W{b1[BYTE_W-1]}}, b1};
        seq_pc   = opnd_pc + ADDR_W'(1);
        idx_base = (mode == AM_IDXB) ? iy : ix;
    end

    // Mode multiplexer for the effective address.
    always_comb begin
        case (mode)
            AM_IMM:           ea = opnd_pc;
            AM_ZPG:           ea = {{HI_W{1'b0}}, b1};
            AM_ABS:           ea = {b1, b2};
            AM_IDXA, AM_IDXB: ea = idx_base + off_zx;
            AM_BRA:           ea = taken ? (seq_pc + off_sx) : seq_pc;
            default:          ea = '0;
        endcase
        ea_valid = mode_has_ea(mode);
    end

endmodule

// File: rtl/ea_gen_len.sv
// Length calculator: selector byte + opcode + operand bytes.
// Assumes at most one selector byte precedes an opcode.
module ea_gen_len
    import ea_gen_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  amode_e            mode,
    input  logic              wide,
    input  logic              sel_cnt,
    output logic [LEN_W-1:0]  len
);
    // Sum the three parts of the instruction.
    always_comb begin
        len = LEN_W'(sel_cnt) + LEN_W'(1) + LEN_W'(operand_bytes(mode, wide));
    end
endmodule

// File: rtl/ea_gen.sv
// Effective address generator top: registers the address, its valid flag,
// the opcode page and the instruction length one cycle after issue.
// Assumes ins_valid is presented with all operand fields stable for one cycle.
module ea_gen
    import ea_gen_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 3,
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_we,
    input  logic [BYTE_W-1:0] pre_byte,
    input  logic              ins_valid,
    input  logic [2:0]        mode,
    input  logic              wide,
    input  logic [BYTE_W-1:0] opnd_b1,
    input  logic [BYTE_W-1:0] opnd_b2,
    input  logic [ADDR_W-1:0] ix,
    input  logic [ADDR_W-1:0] iy,
    input  logic [ADDR_W-1:0] opnd_pc,
    input  logic              taken,
    output logic [ADDR_W-1:0] ea,
    output logic              ea_valid,
    output logic [LEN_W-1:0]  ins_len,
    output logic [PAGE_W-1:0] page,
    output logic              out_valid
);
    localparam int HI_W = ADDR_W - BYTE_W;

    amode_e            mode_e;
    logic [PAGE_W-1:0] cur_page;
    logic              sel_cnt;
    logic [ADDR_W-1:0] ea_c;
    logic              ea_valid_c;
    logic [LEN_W-1:0]  len_c;
    amode_e            mode_q;

    assign mode_e = amode_e'(mode);

    ea_gen_page #(.BYTE_W(BYTE_W), .PAGE_W(PAGE_W)) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_we    (pre_we),
        .pre_byte  (pre_byte),
        .ins_valid (ins_valid),
        .page_o    (cur_page),
        .sel_cnt_o (sel_cnt)
    );

    ea_gen_calc #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_calc (
        .mode     (mode_e),
        .b1       (opnd_b1),
        .b2       (opnd_b2),
        .ix       (ix),
        .iy       (iy),
        .opnd_pc  (opnd_pc),
        .taken    (taken),
        .ea       (ea_c),
        .ea_valid (ea_valid_c)
    );

    ea_gen_len #(.LEN_W(LEN_W)) u_len (
        .mode    (mode_e),
        .wide    (wide),
        .sel_cnt (sel_cnt),
        .len     (len_c)
    );

    // Capture results on issue; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea       <= '0;
            ea_valid <= 1'b0;
            ins_len  <= '0;
            page     <= '0;
            mode_q   <= AM_NONE;
        end else if (ins_valid) begin
            ea       <= ea_c;
            ea_valid <= ea_valid_c;
            ins_len  <= len_c;
            page     <= cur_page;
            mode_q   <= mode_e;
        end
    end

    // Issue strobe, delayed by one register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= ins_valid;
    end

    a_r2_zero_page_high: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_q == AM_ZPG) |-> (ea[ADDR_W-1:BYTE_W] == HI_W'(0)));

    a_r7_no_address: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (mode_q == AM_NONE || mode_q == AM_SPARE)) |-> (!ea_valid && ea == '0));

    a_r9_len_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ins_len >= LEN_W'(1) && ins_len <= LEN_W'(4)));

    a_r10_issue_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> out_valid);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |=> (!out_valid && $stable(ea) && $stable(ins_len) && $stable(page)));

endmodule

// File: tb/test_ea_gen.sv
// Bench: seeded random instructions with random selector bytes, plus directed
// orderings and wrap cases, checked against bench reference functions.
module test_ea_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pre_we = 1'b0;
    logic [7:0]  pre_byte = '0;
    logic        ins_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic        wide = 1'b0;
    logic [7:0]  opnd_b1 = '0;
    logic [7:0]  opnd_b2 = '0;
    logic [15:0] ix = '0;
    logic [15:0] iy = '0;
    logic [15:0] opnd_pc = '0;
    logic        taken = 1'b0;
    logic [15:0] ea;
    logic        ea_valid;
    logic [2:0]  ins_len;
    logic [1:0]  page;
    logic        out_valid;

    int          n_checks = 0;
    int          n_errors = 0;
    int          cycles = 0;
    logic [1:0]  m_page = '0;

    always #10 clk = ~clk;

    ea_gen i_ea_gen (
        .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_byte(pre_byte),
        .ins_valid(ins_valid), .mode(mode), .wide(wide), .opnd_b1(opnd_b1),
        .opnd_b2(opnd_b2), .ix(ix), .iy(iy), .opnd_pc(opnd_pc), .taken(taken),
        .ea(ea), .ea_valid(ea_valid), .ins_len(ins_len), .page(page),
        .out_valid(out_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] sel_page(input logic [7:0] v);
        case (v)
            8'h18:   sel_page = 2'd1;
            8'h1A:   sel_page = 2'd2;
            8'hCD:   sel_page = 2'd3;
            default: sel_page = 2'd0;
        endcase
    endfunction

    function automatic logic [15:0] ref_ea(input logic [2:0] m, input logic [7:0] a,
            input logic [7:0] b, input logic [15:0] x, input logic [15:0] y,
            input logic [15:0] pc, input logic tk);
        logic [16:0] s;
        case (m)
            3'd1: ref_ea = pc;
            3'd2: ref_ea = {8'h00, a};
            3'd3: ref_ea = {a, b};
            3'd4: begin s = {1'b0, x} + {9'd0, a}; ref_ea = s[15:0]; end
            3'd5: begin s = {1'b0, y} + {9'd0, a}; ref_ea = s[15:0]; end
            3'd6: begin
                s = {1'b0, pc} + 17'd1;
                if (tk) s = s + {{9{a[7]}}, a};
                ref_ea = s[15:0];
            end
            default: ref_ea = 16'h0000;
        endcase
    endfunction

    function automatic logic [2:0] ref_len(input logic [2:0] m, input logic w, input logic [1:0] pg);
        int n;
        case (m)
            3'd1:                n = w ? 2 : 1;
            3'd2, 3'd4, 3'd5, 3'd6: n = 1;
            3'd3:                n = 2;
            default:             n = 0;
        endcase
        ref_len = 3'(n + 1 + ((pg != 0) ? 1 : 0));
    endfunction

    // Present a lone candidate selector byte for one cycle.
    task automatic send_sel(input logic [7:0] v);
        @(negedge clk);
        pre_we = 1'b1; pre_byte = v;
        if (sel_page(v) != 0) m_page = sel_page(v);
        @(negedge clk);
        pre_we = 1'b0;
        check("R10 no strobe without issue", 32'(out_valid), 32'd0);
    endtask

    // Issue one instruction, optionally with a same-cycle selector, then check.
    task automatic issue(input logic [2:0] m, input logic w, input logic [7:0] a,
            input logic [7:0] b, input logic [15:0] x, input logic [15:0] y,
            input logic [15:0] pc, input logic tk, input logic sw, input logic [7:0] sv);
        logic [1:0] pg;
        string tag;
        @(negedge clk);
        ins_valid = 1'b1; mode = m; wide = w; opnd_b1 = a; opnd_b2 = b;
        ix = x; iy = y; opnd_pc = pc; taken = tk; pre_we = sw; pre_byte = sv;
        pg = m_page;
        m_page = (sw && sel_page(sv) != 0) ? sel_page(sv) : 2'd0;
        @(negedge clk);
        ins_valid = 1'b0; pre_we = 1'b0;
        case (m)
            3'd1: tag = "R6 immediate ea";
            3'd2: tag = "R2 zero-page ea";
            3'd3: tag = "R3 absolute ea";
            3'd4, 3'd5: tag = "R4 indexed ea";
            3'd6: tag = "R5 branch ea";
            default: tag = "R7 no-address ea";
        endcase
        check(tag, 32'(ea), 32'(ref_ea(m, a, b, x, y, pc, tk)));
        check("R7 ea_valid", 32'(ea_valid), 32'((m != 3'd0 && m != 3'd7) ? 1 : 0));
        check("R9 ins_len", 32'(ins_len), 32'(ref_len(m, w, pg)));
        check("R8 page", 32'(page), 32'(pg));
        check("R10 out_valid", 32'(out_valid), 32'd1);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_errors++;
            $display("FAIL R10 watchdog act=%0d exp=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", 32'(out_valid), 32'd0);
        check("R1 reset ea", 32'(ea), 32'd0);
        check("R1 reset ea_valid", 32'(ea_valid), 32'd0);
        check("R1 reset ins_len", 32'(ins_len), 32'd0);
        check("R1 reset page", 32'(page), 32'd0);
        rst_n = 1'b1;

        // Directed corner cases.
        issue(3'd2, 0, 8'hFF, 8'h00, 0, 0, 16'h1234, 0, 0, 0);           // R2
        issue(3'd3, 0, 8'hAB, 8'hCD, 0, 0, 16'h0000, 0, 0, 0);           // R3 high byte first
        issue(3'd4, 0, 8'h80, 8'h00, 16'hFFC0, 16'h0, 16'h0, 0, 0, 0);   // R4 wrap on ix
        issue(3'd5, 0, 8'hFF, 8'h00, 16'h0, 16'hFF01, 16'h0, 0, 0, 0);   // R4 wrap on iy
        issue(3'd6, 0, 8'h80, 8'h00, 0, 0, 16'h0010, 1, 0, 0);           // R5 backward
        issue(3'd6, 0, 8'h7F, 8'h00, 0, 0, 16'hFFF0, 1, 0, 0);           // R5 forward wrap
        issue(3'd6, 0, 8'h7F, 8'h00, 0, 0, 16'hFFFF, 0, 0, 0);           // R5 not taken wraps
        issue(3'd1, 1, 8'h12, 8'h34, 0, 0, 16'h4000, 0, 0, 0);           // R6 wide
        issue(3'd0, 0, 8'h12, 8'h34, 16'h5555, 0, 16'h4000, 1, 0, 0);    // R7
        issue(3'd7, 1, 8'h12, 8'h34, 0, 0, 16'h4000, 1, 0, 0);           // R7 spare
        send_sel(8'h18); issue(3'd5, 0, 8'h01, 0, 0, 16'h2000, 0, 0, 0, 0);   // R8 page 1
        issue(3'd3, 0, 8'h00, 8'h01, 0, 0, 0, 0, 0, 0);                  // R8 back to 0
        send_sel(8'h1A); send_sel(8'h55); issue(3'd1, 1, 0, 0, 0, 0, 16'h10, 0, 0, 0); // R8 ignored byte
        send_sel(8'h18); send_sel(8'hCD); issue(3'd3, 0, 1, 2, 0, 0, 0, 0, 0, 0);      // R8 later wins
        issue(3'd2, 0, 8'h40, 0, 0, 0, 0, 0, 1, 8'h1A);                  // R8 same-cycle selector
        issue(3'd4, 0, 8'h40, 0, 16'h1000, 0, 0, 0, 0, 0);               // R8 page 2 now used
        held = ea;
        @(negedge clk);
        check("R10 idle out_valid", 32'(out_valid), 32'd0);
        check("R10 idle ea held", 32'(ea), 32'(held));

        // Seeded random mix.
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom_range(0, 4));
            if (r == 1) send_sel(8'h18);
            else if (r == 2) send_sel(8'($urandom_range(0, 255)));
            else if (r == 3) send_sel(($urandom_range(0, 1) == 1) ? 8'hCD : 8'h1A);
            repeat (int'($urandom_range(0, 2))) begin
                @(negedge clk);
                check("R10 gap out_valid", 32'(out_valid), 32'd0);
            end
            issue(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                  8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)),
                  16'($urandom_range(0, 65535)), 16'($urandom_range(0, 65535)),
                  16'($urandom_range(0, 65535)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 3) == 0), 8'h18);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule